// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block produces the bus activity a small 8-bit processor goes through when it enters a service routine. The routine can start from a reset, a non-maskable interrupt, a maskable interrupt or a software break. Each cycle, the block drives a 16-bit address, a read/write line and write data. It also keeps the program counter and the 8-bit stack pointer that the sequence changes.

All four sources run through one seven-cycle sequence. The sequence starts with two reads at the program counter. It then makes three stack cycles, which save the program counter high byte, the program counter low byte and the status byte while the stack pointer steps down. Last, it makes two reads that fetch the service vector, low byte first, into the program counter. A reset follows the same path, but its stack cycles become reads, so memory is never written during a reset. The stack pointer still moves during those reads. A software break advances the program counter in its first two cycles. A hardware source leaves the program counter unchanged in those cycles.

Top module: `ent_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy` and `done` are 0, `rw` is 1, and `pc_out` is 0.
- R2: A request seen while `busy` is 0 starts a sequence at that clock edge. `busy` is then 1 for exactly seven cycles, and any request that arrives while `busy` is 1 is ignored.
- R3: When several requests arrive in the same cycle, reset wins over the non-maskable interrupt, which wins over the maskable interrupt, which wins over break.
- R4: For reset and both interrupts, cycles 1 and 2 are reads (`rw`=1) at the captured program counter, and the program counter does not change during them.
- R5: For break, cycle 1 reads at the captured program counter P and cycle 2 reads at P+1. The program counter that is saved is P+2.
- R6: Cycles 3, 4 and 5 address {8'h01, SP}, where SP is the current stack pointer, which drops by one after each of these cycles. The bytes go out in the order program counter high, program counter low, status. At the end, `sp_out` equals the captured stack pointer minus 3.
- R7: `rw` is 0 during cycles 3 to 5 for both interrupts and for break. During a reset sequence, `rw` is 1 in every cycle.
- R8: The saved status byte is `status_in` with bit 4 set for break and bit 4 cleared for either interrupt.
- R9: Cycle 6 reads the vector low byte and cycle 7 reads the vector high byte. The vectors are $FFFA/$FFFB for the non-maskable interrupt, $FFFC/$FFFD for reset, and $FFFE/$FFFF for the maskable interrupt and for break. When `done` is 1, `pc_out` equals {high byte, low byte}.
- R10: While idle, `addr` equals `pc_out` and `rw` is 1.
- R11: `done` is 1 for exactly one cycle, the one right after cycle 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset entry request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_irq | input | 1 | Maskable interrupt request |
| req_brk | input | 1 | Software break request |
| pc_in | input | 16 | Program counter captured at start |
| sp_in | input | 8 | Stack pointer captured at start |
| status_in | input | 8 | Status byte captured at start |
| rdata | input | 8 | Read data from the bus |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| wdata | output | 8 | Write data |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse once the vector is loaded |

## Verification
Two functions of this block can land in the same cycle: choosing among simultaneous requests, and ignoring a request that arrives while a sequence is running. The bench raises random subsets of the four requests in a single cycle and checks that every bus cycle matches the winner that the priority order predicts. In chosen runs it raises all four requests in the middle of the stack cycles. The bench then checks that the sequence runs to its end unchanged, and that `busy` stays low in the cycle after `done`.

// File: rtl/ent_pkg.sv
package ent_pkg;
  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_NMI = 2'd1,
    SRC_IRQ = 2'd2,
    SRC_BRK = 2'd3
  } src_e;

  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned NUM_STEP = 7;
  localparam int unsigned STEP_W   = $clog2(NUM_STEP);

  // Low address of the vector pair for each source.
  function automatic logic [15:0] vec_base(src_e s);
    case (s)
      SRC_NMI: vec_base = 16'hFFFA;
      SRC_RST: vec_base = 16'hFFFC;
      default: vec_base = 16'hFFFE;
    endcase
  endfunction
endpackage

// File: rtl/ent_arb.sv
module ent_arb
  import ent_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  output logic               valid,
  output src_e               src
);
  logic [NUM_SRC-1:0] grant;

  // Lowest index wins: reset, nmi, irq, brk.
  always_comb begin
    grant = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) grant = NUM_SRC'(1) << i;
    end
  end

  always_comb begin
    src = SRC_BRK;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (grant[i]) src = src_e'(i);
    end
  end

  assign valid = |req;

  assert_grant_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  assert_reset_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> src == SRC_RST);
  assert_nmi_over_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req[0] && req[1]) |-> src == SRC_NMI);
endmodule

// File: rtl/ent_ctl.sv
module ent_ctl
  import ent_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEP - 1);

  logic              busy_d, done_d;
  logic [STEP_W-1:0] step_d;
  logic              step_en;

  assign step_en = busy || start;

  always_comb begin
    busy_d = busy;
    step_d = step;
    done_d = 1'b0;
    if (busy) begin
      if (step == LAST) begin
        busy_d = 1'b0;
        step_d = '0;
        done_d = 1'b1;
      end else begin
        step_d = step + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (step_en) begin
      busy <= busy_d;
      step <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= done_d;
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && $past(step) == LAST && !busy));
  assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != LAST) |=> (busy && step == $past(step) + 1'b1));
endmodule

// File: rtl/ent_dp.sv
module ent_dp
  import ent_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned SPW        = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter int unsigned BRK_BIT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  src_e              src_in,
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     pc_in,
  input  logic [SPW-1:0]    sp_in,
  input  logic [DW-1:0]     st_in,
  input  logic [DW-1:0]     rdata,
  output logic [AW-1:0]     addr,
  output logic              rw,
  output logic [DW-1:0]     wdata,
  output logic [AW-1:0]     pc_q,
  output logic [SPW-1:0]    sp_q
);
  localparam int unsigned HB = AW - DW;

  src_e           src_q;
  logic [DW-1:0]  st_q;
  logic [AW-1:0]  pc_d;
  logic [SPW-1:0] sp_d;
  logic           is_push, is_brk;
  logic [AW-1:0]  vec;

  assign is_brk  = (src_q == SRC_BRK);
  assign is_push = busy && step >= STEP_W'(2) && step <= STEP_W'(4);
  assign vec     = vec_base(src_q);

  always_comb begin
    pc_d = pc_q;
    sp_d = sp_q;
    if (start && !busy) begin
      pc_d = pc_in;
      sp_d = sp_in;
    end else if (busy) begin
      case (step)
        STEP_W'(0), STEP_W'(1): if (is_brk) pc_d = pc_q + 1'b1;
        STEP_W'(2), STEP_W'(3), STEP_W'(4): sp_d = sp_q - 1'b1;
        STEP_W'(5): pc_d[DW-1:0] = rdata;
        STEP_W'(6): pc_d[AW-1:HB] = rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      pc_q <= pc_d;
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_RST;
      st_q  <= '0;
    end else if (start && !busy) begin
      src_q <= src_in;
      st_q  <= st_in;
    end
  end

  always_comb begin
    addr  = pc_q;
    rw    = 1'b1;
    wdata = '0;
    if (is_push) begin
      addr = {STACK_PAGE, sp_q};
      rw   = (src_q == SRC_RST);
      case (step)
        STEP_W'(2): wdata = pc_q[AW-1:HB];
        STEP_W'(3): wdata = pc_q[DW-1:0];
        default: begin
          wdata          = st_q;
          wdata[BRK_BIT] = is_brk;
        end
      endcase
    end else if (busy && step == STEP_W'(5)) begin
      addr = vec;
    end else if (busy && step == STEP_W'(6)) begin
      addr = vec + 1'b1;
    end
  end

  assert_sp_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_push |=> sp_q == $past(sp_q) - 1'b1);
  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step <= STEP_W'(1) && !is_brk) |=> pc_q == $past(pc_q));
  assert_reset_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_q == SRC_RST) |-> rw);
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rw && addr == pc_q));
endmodule

// File: rtl/ent_seq.sv
module ent_seq
  import ent_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned SPW        = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter int unsigned BRK_BIT    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_reset,
  input  logic           req_nmi,
  input  logic           req_irq,
  input  logic           req_brk,
  input  logic [AW-1:0]  pc_in,
  input  logic [SPW-1:0] sp_in,
  input  logic [DW-1:0]  status_in,
  input  logic [DW-1:0]  rdata,
  output logic [AW-1:0]  addr,
  output logic           rw,
  output logic [DW-1:0]  wdata,
  output logic [AW-1:0]  pc_out,
  output logic [SPW-1:0] sp_out,
  output logic           busy,
  output logic           done
);
  logic              req_valid, start;
  src_e              win;
  logic [STEP_W-1:0] step;

  ent_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   ({req_brk, req_irq, req_nmi, req_reset}),
    .valid (req_valid),
    .src   (win)
  );

  assign start = req_valid && !busy;

  ent_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .step  (step),
    .done  (done)
  );

  ent_dp #(
    .AW(AW), .DW(DW), .SPW(SPW), .STACK_PAGE(STACK_PAGE), .BRK_BIT(BRK_BIT)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .src_in (win),
    .busy   (busy),
    .step   (step),
    .pc_in  (pc_in),
    .sp_in  (sp_in),
    .st_in  (status_in),
    .rdata  (rdata),
    .addr   (addr),
    .rw     (rw),
    .wdata  (wdata),
    .pc_q   (pc_out),
    .sp_q   (sp_out)
  );

  assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != STEP_W'(NUM_STEP - 1)) |=> busy);
endmodule

// File: tb/sim_ent_seq.sv
`timescale 1ns/1ps
module sim_ent_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req;
  logic [15:0] pc_in;
  logic [7:0]  sp_in, status_in, rdata, wdata, sp_out;
  logic [15:0] addr, pc_out;
  logic        rw, busy, done;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  // Bus memory model: contents computed from the address.
  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rdata = mem(addr);

  ent_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req[0]), .req_nmi(req[1]), .req_irq(req[2]), .req_brk(req[3]),
    .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in), .rdata(rdata),
    .addr(addr), .rw(rw), .wdata(wdata), .pc_out(pc_out), .sp_out(sp_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // 0 reset, 1 nmi, 2 irq, 3 brk
  function automatic int winner(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] vector(input int w);
    return (w == 1) ? 16'hFFFA : (w == 0) ? 16'hFFFC : 16'hFFFE;
  endfunction

  task automatic run(input logic [3:0] r, input logic [15:0] p, input logic [7:0] s,
                     input logic [7:0] st, input bit inject);
    int w = winner(r);
    logic [15:0] ppc = (w == 3) ? p + 16'd2 : p;
    logic [15:0] v = vector(w);
    logic [7:0]  est;
    @(negedge clk);
    req = r; pc_in = p; sp_in = s; status_in = st;
    @(negedge clk);
    req = '0;
    for (int k = 0; k < 7; k++) begin
      chk(busy == 1'b1, "R2 busy", busy, 1);
      case (k)
        0: begin
          chk(addr == p && rw, "R4 step1 read pc", {addr, 7'd0, rw}, {p, 8'd1});
        end
        1: begin
          if (w == 3) chk(addr == p + 16'd1 && rw, "R5 step2 brk pc+1", addr, p + 16'd1);
          else        chk(addr == p && rw, "R4 step2 dummy pc", addr, p);
        end
        2, 3, 4: begin
          chk(addr == {8'h01, 8'(s - 8'(k - 2))}, "R6 stack addr", addr,
              {8'h01, 8'(s - 8'(k - 2))});
          chk(rw == (w == 0), "R7 rw on stack cycle", rw, (w == 0));
          if (w != 0) begin
            if (k == 2) chk(wdata == ppc[15:8], "R6 push pc hi", wdata, ppc[15:8]);
            if (k == 3) chk(wdata == ppc[7:0], "R6 push pc lo", wdata, ppc[7:0]);
            if (k == 4) begin
              est = st; est[4] = (w == 3);
              chk(wdata == est, "R8 status byte", wdata, est);
            end
          end
        end
        5: chk(addr == v && rw, "R9 vector low addr", addr, v);
        default: chk(addr == v + 16'd1 && rw, "R9 vector high addr", addr, v + 16'd1);
      endcase
      if (inject && k == 3) req = 4'hF;
      if (inject && k == 4) req = 4'h0;
      @(negedge clk);
    end
    chk(done && !busy, "R11 done after seventh cycle", {done, busy}, 2'b10);
    chk(pc_out == {mem(v + 16'd1), mem(v)}, "R9 pc from vector", pc_out,
        {mem(v + 16'd1), mem(v)});
    chk(sp_out == s - 8'd3, "R6 final sp", sp_out, s - 8'd3);
    chk(addr == pc_out && rw, "R10 idle bus", addr, pc_out);
    @(negedge clk);
    chk(!done && !busy, "R2 R11 single done, ignored request", {done, busy}, 0);
  endtask

  initial begin
    req = '0; pc_in = '0; sp_in = '0; status_in = '0;
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && rw, "R1 in reset", {busy, done, rw}, 3'b001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && rw && pc_out == 0, "R1 after reset", {busy, done, rw}, 3'b001);
    // directed corners
    run(4'b0001, 16'h1234, 8'hFD, 8'h00, 0);  // reset alone, R7 reads
    run(4'b0010, 16'h80FF, 8'h00, 8'hFF, 0);  // nmi, sp wraps
    run(4'b0100, 16'hC000, 8'hFF, 8'h10, 0);  // irq clears bit 4
    run(4'b1000, 16'hFFFF, 8'h02, 8'h00, 0);  // brk, pc wraps
    run(4'b1111, 16'h4321, 8'h80, 8'h5A, 1);  // R3 all at once + ignored while busy
    run(4'b1110, 16'h0100, 8'h40, 8'hAA, 0);  // R3 nmi beats irq/brk
    run(4'b1100, 16'h0200, 8'h41, 8'h3C, 1);  // R3 irq beats brk
    void'($urandom(32'd1234));
    for (int n = 0; n < 40; n++) begin
      logic [3:0] r = 4'($urandom_range(1, 15));
      run(r, 16'($urandom), 8'($urandom), 8'($urandom), bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule